// File: doc/BRIEF.md
# Row Scan Sequencer with Cyclic Scrolling

The sequencer sets the order in which the logical rows of a display memory are read out to the row drivers during each frame. A frame is a run of slots. Each slot takes a fixed number of oscillator ticks and belongs to one row driver. The first slots carry the graphic rows. The final slot always carries the icon row. In full mode there are 64 graphic rows plus the icon row, so a frame has 65 slots. In half mode there are 32 graphic rows plus the icon row, so a frame has 33 slots. With the default of 8 ticks per slot, a full-mode frame lasts 520 oscillator ticks.

A scroll pulse moves a cyclic offset by one raster row, in the direction set by a direction input. The offset added to the slot index picks the graphic row that is read. A row-reversal input flips the graphic read order. The icon row takes no part in scrolling or reversal. Each frame latches the offset when it begins, so a frame is never torn partway through. Changing the mux mode restarts the frame and clears the offset.

A small state machine does the sequencing. It has two states. SEQ_GFX walks the graphic slots. SEQ_ICON holds the icon slot. The transitions are:
- GFX→ICON, taken after the last graphic slot.
- ICON→GFX, the frame wrap.
- any→GFX, the restart taken on a mode change.

Top module: `scan_row_sequencer`

## Requirements
- R1: `drv_idx` steps 0,1,…,N and then returns to 0. Each value is held for TICKS_PER_ROW cycles with `tick` high. N is 64 when `mux_half`=0 and 32 when `mux_half`=1.
- R2: `frame_start` is high for exactly one cycle, the first cycle in which `drv_idx` is 0 after a frame wrap or a restart. With `tick` held high in full mode, successive frame starts are 520 cycles apart.
- R3: A `scroll` pulse raises the offset by one when `scroll_dn`=0 and lowers it by one when `scroll_dn`=1. The offset wraps cyclically within 0…N-1.
- R4: In a graphic slot, let b = (drv_idx + frame offset) mod N. Then `mem_row` = b when `row_rev`=0, and `mem_row` = N-1-b when `row_rev`=1.
- R5: In the icon slot (drv_idx = N), `mem_row` = N, whatever the offset and `row_rev` are.
- R6: A frame uses the offset latched on its wrap edge. That value includes a scroll pulse applied in the same cycle as the wrap. A scroll in the middle of a frame takes effect in the next frame.
- R7: After reset, `drv_idx`=0, `mem_row`=0, `frame_start`=0, the offset is 0 and full mode is in effect.
- R8: When `mux_half` differs from the registered mode, the next edge restarts the frame at slot 0 and clears the offset. A scroll pulse in that same cycle is discarded.
- R9: While `tick` is low, `drv_idx` and `mem_row` do not advance. Scroll pulses are still counted.
- R10: In half mode a frame has 33 slots, and the offset wraps at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator tick enable |
| mux_half | input | 1 | 1 = 33-slot half mode, 0 = 65-slot full mode |
| row_rev | input | 1 | 1 = reverse the graphic row read order |
| scroll | input | 1 | One-cycle scroll command |
| scroll_dn | input | 1 | Scroll direction: 0 = offset up, 1 = offset down |
| drv_idx | output | 7 | Current row driver slot |
| mem_row | output | 7 | Logical memory row to read in this slot |
| frame_start | output | 1 | One-cycle marker at the start of a frame |

## Verification
Two events can land in the same cycle. The first case is a scroll pulse on the edge where the icon slot wraps back to slot 0. The bench provokes it by waiting until its model stands at the last tick of the icon slot and raising `scroll` for that one cycle. It judges the case by whether the rows of the new frame already carry the shifted offset. The second case is a mode change that arrives together with a scroll pulse. The bench checks that the new frame starts from offset 0, so the scroll is discarded.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [0:0] {
        SEQ_GFX  = 1'b0,
        SEQ_ICON = 1'b1
    } seq_state_t;
endpackage

// File: rtl/rss_scroll_offset.sv
module rss_scroll_offset #(
    parameter int GFX_ROWS = 64,
    localparam int OW = $clog2(GFX_ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          half_mode,
    input  logic          scroll,
    input  logic          scroll_dn,
    output logic [OW-1:0] off_q,
    output logic [OW-1:0] off_nxt
);
    localparam logic [OW-1:0] LIM_FULL = OW'(GFX_ROWS - 1);
    localparam logic [OW-1:0] LIM_HALF = OW'(GFX_ROWS / 2 - 1);

    logic [OW-1:0] lim;
    assign lim = half_mode ? LIM_HALF : LIM_FULL;

    always_comb begin
        off_nxt = off_q;
        if (restart) begin
            off_nxt = '0;
        end else if (scroll) begin
            if (!scroll_dn) off_nxt = (off_q == lim) ? '0 : off_q + 1'b1;
            else            off_nxt = (off_q == '0) ? lim : off_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_nxt;
    end

    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> off_q == '0); // R8
    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= lim); // R3
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !scroll) |=> $stable(off_q)); // R3
endmodule

// File: rtl/rss_slot_fsm.sv
module rss_slot_fsm
    import rss_pkg::*;
#(
    parameter int GFX_ROWS      = 64,
    parameter int TICKS_PER_ROW = 8,
    localparam int IW = $clog2(GFX_ROWS + 1),
    localparam int SW = (TICKS_PER_ROW > 1) ? $clog2(TICKS_PER_ROW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          half_mode,
    input  logic          tick,
    output seq_state_t    state_q,
    output logic [IW-1:0] slot_q,
    output logic          wrap,
    output logic          frame_start
);
    localparam logic [SW-1:0] SUB_LAST  = SW'(TICKS_PER_ROW - 1);
    localparam logic [IW-1:0] LAST_FULL = IW'(GFX_ROWS - 1);
    localparam logic [IW-1:0] LAST_HALF = IW'(GFX_ROWS / 2 - 1);

    seq_state_t    state_d;
    logic [IW-1:0] slot_d;
    logic [SW-1:0] sub_q, sub_d;
    logic [IW-1:0] last_gfx;

    assign last_gfx = half_mode ? LAST_HALF : LAST_FULL;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        sub_d   = sub_q;
        wrap    = 1'b0;
        if (restart) begin
            state_d = SEQ_GFX;
            slot_d  = '0;
            sub_d   = '0;
        end else if (tick) begin
            if (sub_q == SUB_LAST) begin
                sub_d = '0;
                unique case (state_q)
                    SEQ_GFX: begin
                        if (slot_q == last_gfx) state_d = SEQ_ICON;
                        slot_d = slot_q + 1'b1;
                    end
                    SEQ_ICON: begin
                        state_d = SEQ_GFX;
                        slot_d  = '0;
                        wrap    = 1'b1;
                    end
                endcase
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_GFX;
            slot_q  <= '0;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            sub_q   <= sub_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= restart | wrap;
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= IW'(GFX_ROWS)); // R1
    AST_ICON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ICON) |-> (slot_q == last_gfx + 1'b1)); // R5
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> ($stable(slot_q) && $stable(sub_q))); // R9
    AST_FS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_q == '0 && state_q == SEQ_GFX)); // R2
endmodule

// File: rtl/rss_row_map.sv
module rss_row_map
    import rss_pkg::*;
#(
    parameter int GFX_ROWS = 64,
    localparam int OW = $clog2(GFX_ROWS),
    localparam int IW = $clog2(GFX_ROWS + 1)
) (
    input  seq_state_t    state,
    input  logic [IW-1:0] slot,
    input  logic [OW-1:0] frame_off,
    input  logic          half_mode,
    input  logic          row_rev,
    output logic [IW-1:0] mem_row
);
    localparam logic [OW-1:0] MASK_FULL = OW'(GFX_ROWS - 1);
    localparam logic [OW-1:0] MASK_HALF = OW'(GFX_ROWS / 2 - 1);

    logic [OW-1:0] mask, sum, base, row;

    always_comb begin
        mask = half_mode ? MASK_HALF : MASK_FULL;
        sum  = slot[OW-1:0] + frame_off;
        base = sum & mask;
        row  = row_rev ? (mask - base) : base;
        if (state == SEQ_ICON) mem_row = IW'(mask) + 1'b1;
        else                   mem_row = IW'(row);
    end
endmodule

// File: rtl/scan_row_sequencer.sv
module scan_row_sequencer
    import rss_pkg::*;
#(
    parameter int GFX_ROWS      = 64,
    parameter int TICKS_PER_ROW = 8,
    localparam int OW = $clog2(GFX_ROWS),
    localparam int IW = $clog2(GFX_ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mux_half,
    input  logic          row_rev,
    input  logic          scroll,
    input  logic          scroll_dn,
    output logic [IW-1:0] drv_idx,
    output logic [IW-1:0] mem_row,
    output logic          frame_start
);
    logic          mode_q;
    logic          restart;
    logic          wrap;
    seq_state_t    state_q;
    logic [OW-1:0] off_q, off_nxt, frame_off;

    assign restart = (mux_half != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mux_half;
    end

    rss_scroll_offset #(.GFX_ROWS(GFX_ROWS)) u_offset (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .half_mode (mode_q),
        .scroll    (scroll),
        .scroll_dn (scroll_dn),
        .off_q     (off_q),
        .off_nxt   (off_nxt)
    );

    rss_slot_fsm #(.GFX_ROWS(GFX_ROWS), .TICKS_PER_ROW(TICKS_PER_ROW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .half_mode   (mode_q),
        .tick        (tick),
        .state_q     (state_q),
        .slot_q      (drv_idx),
        .wrap        (wrap),
        .frame_start (frame_start)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       frame_off <= '0;
        else if (restart) frame_off <= '0;
        else if (wrap)    frame_off <= off_nxt;
    end

    rss_row_map #(.GFX_ROWS(GFX_ROWS)) u_map (
        .state     (state_q),
        .slot      (drv_idx),
        .frame_off (frame_off),
        .half_mode (mode_q),
        .row_rev   (row_rev),
        .mem_row   (mem_row)
    );

    AST_ICON_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ICON) |-> (mem_row == (mode_q ? IW'(GFX_ROWS / 2) : IW'(GFX_ROWS)))); // R5
    AST_FOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !restart) |=> $stable(frame_off)); // R6
    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (drv_idx == '0 && frame_start)); // R8
    AST_GFX_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GFX) |-> (mem_row < (mode_q ? IW'(GFX_ROWS / 2) : IW'(GFX_ROWS)))); // R4
endmodule

// File: tb/scan_row_sequencer_bench.sv
module scan_row_sequencer_bench;
    localparam int TPR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, mux_half = 1'b0, row_rev = 1'b0;
    logic       scroll = 1'b0, scroll_dn = 1'b0;
    logic [6:0] drv_idx, mem_row;
    logic       frame_start;

    int checks = 0, fails = 0;
    int m_mode = 0, m_slot = 0, m_sub = 0, m_off = 0, m_foff = 0, m_fs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scan_row_sequencer u_scan_row_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mux_half(mux_half),
        .row_rev(row_rev), .scroll(scroll), .scroll_dn(scroll_dn),
        .drv_idx(drv_idx), .mem_row(mem_row), .frame_start(frame_start)
    );

    function automatic int rows_n();
        return (m_mode != 0) ? 32 : 64;
    endfunction

    function automatic int exp_row();
        int n = rows_n();
        int b;
        if (m_slot == n) return n;
        b = (m_slot + m_foff) % n;
        return row_rev ? (n - 1 - b) : b;
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp(input string tag);
        int er = exp_row();
        checks++;
        if (drv_idx != 7'(m_slot) || mem_row != 7'(er) || frame_start != m_fs[0]) begin
            fails++;
            $display("FAIL %s actual idx=%0d row=%0d fs=%0d expected idx=%0d row=%0d fs=%0d",
                     tag, drv_idx, mem_row, frame_start, m_slot, er, m_fs);
        end
    endtask

    task automatic step(input string tag);
        int n, offn;
        @(posedge clk);
        if (int'(mux_half) != m_mode) begin
            m_mode = int'(mux_half);
            m_slot = 0; m_sub = 0; m_off = 0; m_foff = 0; m_fs = 1;
        end else begin
            n = rows_n();
            offn = m_off;
            if (scroll) offn = scroll_dn ? (m_off + n - 1) % n : (m_off + 1) % n;
            m_fs = 0;
            if (tick) begin
                if (m_sub == TPR - 1) begin
                    m_sub = 0;
                    if (m_slot == n) begin
                        m_slot = 0; m_foff = offn; m_fs = 1;
                    end else m_slot++;
                end else m_sub++;
            end
            m_off = offn;
        end
        @(negedge clk);
        cmp(tag);
        scroll = 1'b0;
    endtask

    task automatic run(input int cyc, input string tag);
        for (int i = 0; i < cyc; i++) step(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int period;
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 idx", drv_idx == 7'd0, drv_idx, 0);
        check("R7 row", mem_row == 7'd0, mem_row, 0);
        check("R7 fs", frame_start == 1'b0, frame_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        tick = 1'b1;
        // R1 slot walk, plain ticking
        run(1100, "R1");
        // R2 frame period
        while (!frame_start) step("R2");
        period = 0;
        do begin step("R2"); period++; end while (!frame_start);
        check("R2 period", period == 520, period, 520);
        // R1 irregular ticks
        for (int i = 0; i < 1500; i++) begin
            tick = (i % 3) != 0;
            step("R1");
        end
        tick = 1'b1;
        // R4/R5 sweep all full-mode offsets, both orders, mid-frame scroll
        for (int k = 0; k < 64; k++) begin
            row_rev = 1'b0; run(300, "R4");
            scroll = 1'b1; scroll_dn = 1'b0;
            run(740, "R4");
            row_rev = 1'b1; run(520, "R5");
        end
        row_rev = 1'b0;
        check("R3 up wrap", m_off == 0, m_off, 0);
        run(1040, "R3");
        // R3 down wrap from 0
        scroll = 1'b1; scroll_dn = 1'b1;
        run(1100, "R3");
        check("R3 down wrap", m_off == 63, m_off, 63);
        // R6 scroll on the wrap edge
        while (!(m_slot == 64 && m_sub == TPR - 1)) step("R6");
        scroll = 1'b1; scroll_dn = 1'b0;
        step("R6");
        check("R6 latched", m_foff == 0 && frame_start, m_foff, 0);
        run(600, "R6");
        // R9 tick low: hold, scroll still counted
        tick = 1'b0;
        run(10, "R9");
        scroll = 1'b1; scroll_dn = 1'b0;
        run(20, "R9");
        tick = 1'b1;
        run(1100, "R9");
        check("R9 scroll counted", m_off == 1, m_off, 1);
        // R8 mode change with coincident scroll
        mux_half = 1'b1; scroll = 1'b1; scroll_dn = 1'b0;
        step("R8");
        check("R8 restart", frame_start == 1'b1 && drv_idx == 7'd0, drv_idx, 0);
        run(600, "R8");
        // R10 half-mode sweep
        for (int k = 0; k < 32; k++) begin
            row_rev = 1'b0; run(100, "R10");
            scroll = 1'b1; scroll_dn = 1'b0;
            run(164, "R10");
            row_rev = 1'b1; run(264, "R10");
        end
        check("R10 wrap", m_off == 0, m_off, 0);
        scroll = 1'b1; scroll_dn = 1'b1;
        run(600, "R10");
        check("R10 down wrap", m_off == 31, m_off, 31);
        // R8 back to full mode
        mux_half = 1'b0;
        step("R8");
        run(1100, "R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule